// File: doc/BRIEF.md
# Converter Power Mode Sequencer

This block sits on the host side of a pipelined analog-to-digital converter and drives its two active-low idle controls: one that shuts the converter down completely and one that puts it into a light sleep. A requester asks for one of three modes (power-down, sleep or running) through a single-cycle command strobe with a two-bit mode code. The block turns each accepted command into the right levels on the two control lines. It counts sample-clock cycles through the converter's wake-up time and then through its pipeline latency, and it raises a data-valid flag only when samples on the converter's output can be trusted.

The converter has to see at least one full power-down after it first powers up, so the block leaves reset holding power-down and cannot be brought to the running mode until that hold has finished. Power-down always wins over sleep. Waking from power-down takes far longer than waking from sleep, and the block applies the matching wait in each case. While a wake is in progress, a busy output is high. During that time an idle request cancels the wake and takes effect at once, and a repeated run request is ignored. The sample clock is taken to be running whenever this block is clocked.

Top module: `adc_pwr_seq`

## Requirements
- R1: While reset is held, pd_n is 0, slp_n is 1, data_valid is 0 and busy is 0.
- R2: After reset is released, pd_n stays 0 for at least RST_HOLD cycles. Every command accepted during that hold is ignored, so a run request made then leaves pd_n at 0 and busy at 0.
- R3: A run command (mode code 2'b10) accepted in power-down sets pd_n to 1 and busy to 1 on the accepting edge. data_valid rises, and busy falls, exactly PD_WAKE + PIPE_LAT edges after that.
- R4: A run command accepted in sleep sets slp_n to 1 and busy to 1 on the accepting edge. data_valid rises exactly SLP_WAKE + PIPE_LAT edges after that.
- R5: A sleep command (mode code 2'b01) accepted while pd_n is 0 is ignored: slp_n stays 1 and pd_n stays 0.
- R6: A power-down command (mode code 2'b00) accepted in any state leaves pd_n at 0, slp_n at 1 and data_valid at 0 after the accepting edge. pd_n and slp_n are never both 0.
- R7: A sleep or power-down command accepted while busy is 1 cancels the wake. On the next edge busy is 0 and the requested idle mode is driven.
- R8: A run command accepted while busy is 1 neither restarts nor shortens the wait: data_valid still rises at the edge set by the first run command.
- R9: The mode code 2'b11 is ignored in every state.
- R10: data_valid is 1 only while pd_n and slp_n are both 1 and busy is 0.
- R11: A sleep command accepted while data_valid is 1 sets slp_n to 0 and data_valid to 0 on the accepting edge, and pd_n stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command strobe, one cycle per command |
| req_mode | input | 2 | Requested mode: 00 power-down, 01 sleep, 10 run, 11 ignored |
| pd_n | output | 1 | Active-low power-down drive to the converter |
| slp_n | output | 1 | Active-low sleep drive to the converter |
| data_valid | output | 1 | Converter output samples are valid |
| busy | output | 1 | A wake-up or pipeline flush is in progress |

## Verification
The bench uses the default parameters: PD_WAKE 900, SLP_WAKE 20, PIPE_LAT 12 and RST_HOLD 4. With these values the full 912-cycle wake from power-down and the 32-cycle wake from sleep are both timed to the exact edge. Because the two windows are so different in length, swapping or shortening one of them, or dropping the flush stage, moves the data_valid edge far enough to be seen. The short reset hold lets a run command land inside the hold, and the sleep wake is short enough that cancels can be placed in both the wake wait and the flush.

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq #(
  parameter int PD_WAKE  = 900,
  parameter int SLP_WAKE = 20,
  parameter int PIPE_LAT = 12,
  parameter int RST_HOLD = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  output logic       pd_n,
  output logic       slp_n,
  output logic       data_valid,
  output logic       busy
);

  localparam int WMAX = (PD_WAKE > SLP_WAKE) ? PD_WAKE : SLP_WAKE;
  localparam int LMAX = (PIPE_LAT > RST_HOLD) ? PIPE_LAT : RST_HOLD;
  localparam int CMAX = (WMAX > LMAX) ? WMAX : LMAX;
  localparam int CW   = $clog2(CMAX + 1);

  localparam logic [1:0] M_PD  = 2'b00;
  localparam logic [1:0] M_SLP = 2'b01;
  localparam logic [1:0] M_RUN = 2'b10;

  typedef enum logic [2:0] {S_RST, S_PD, S_SLP, S_WAKE, S_FLUSH, S_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  wire go_pd  = req_valid && (req_mode == M_PD);
  wire go_slp = req_valid && (req_mode == M_SLP);
  wire go_run = req_valid && (req_mode == M_RUN);
  wire cnt_z  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_RST;
      cnt <= CW'(RST_HOLD - 1);
    end else begin
      case (st)
        S_RST:
          if (cnt_z) st <= S_PD;
          else       cnt <= cnt - 1'b1;
        S_PD:
          if (go_run) begin
            st  <= S_WAKE;
            cnt <= CW'(PD_WAKE - 1);
          end
        S_SLP:
          if (go_pd) st <= S_PD;
          else if (go_run) begin
            st  <= S_WAKE;
            cnt <= CW'(SLP_WAKE - 1);
          end
        S_WAKE:
          if (go_pd)       st <= S_PD;
          else if (go_slp) st <= S_SLP;
          else if (cnt_z) begin
            st  <= S_FLUSH;
            cnt <= CW'(PIPE_LAT - 1);
          end else cnt <= cnt - 1'b1;
        S_FLUSH:
          if (go_pd)       st <= S_PD;
          else if (go_slp) st <= S_SLP;
          else if (cnt_z)  st <= S_RUN;
          else             cnt <= cnt - 1'b1;
        S_RUN:
          if (go_pd)       st <= S_PD;
          else if (go_slp) st <= S_SLP;
        default: st <= S_RST;
      endcase
    end
  end

  assign pd_n       = !((st == S_RST) || (st == S_PD));
  assign slp_n      = (st != S_SLP);
  assign busy       = (st == S_WAKE) || (st == S_FLUSH);
  assign data_valid = (st == S_RUN);

endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_mode,
  input logic       pd_n,
  input logic       slp_n,
  input logic       data_valid,
  input logic       busy
);

  p_valid_awake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (pd_n && slp_n && !busy));

  p_lines_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> slp_n);

  p_pd_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode == 2'b00) |=> (!pd_n && !data_valid));

  p_sleep_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n && req_valid && req_mode == 2'b01) |=> (slp_n && !pd_n));

  p_valid_after_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_valid) |-> $past(busy));

  p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid && req_mode == 2'b01) |=> (!busy && !slp_n));

  p_sleep_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && req_valid && req_mode == 2'b01) |=> (!data_valid && !slp_n && pd_n));

endmodule

bind adc_pwr_seq adc_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .pd_n(pd_n), .slp_n(slp_n), .data_valid(data_valid), .busy(busy)
);

// File: tb/adc_pwr_seq_tb.sv
`timescale 1ns/1ps
module adc_pwr_seq_tb;
  localparam int PDW = 900;
  localparam int SLW = 20;
  localparam int LAT = 12;
  localparam int HLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'b00;
  logic pd_n, slp_n, data_valid, busy;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  adc_pwr_seq #(.PD_WAKE(PDW), .SLP_WAKE(SLW), .PIPE_LAT(LAT), .RST_HOLD(HLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .pd_n(pd_n), .slp_n(slp_n), .data_valid(data_valid), .busy(busy)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [1:0] m);
    req_valid = 1'b1;
    req_mode  = m;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    wait_n(3);
    chk("R1", "pd_n", pd_n, 1'b0);
    chk("R1", "slp_n", slp_n, 1'b1);
    chk("R1", "data_valid", data_valid, 1'b0);
    chk("R1", "busy", busy, 1'b0);
  endtask

  task automatic t_init_hold;
    rst_n = 1'b1;
    send(2'b10);
    chk("R2", "pd_n in hold", pd_n, 1'b0);
    wait_n(HLD + 4);
    chk("R2", "pd_n after hold", pd_n, 1'b0);
    chk("R2", "busy after hold", busy, 1'b0);
  endtask

  task automatic t_ignored_in_pd;
    send(2'b01);
    chk("R5", "slp_n", slp_n, 1'b1);
    chk("R5", "pd_n", pd_n, 1'b0);
    send(2'b11);
    chk("R9", "pd_n", pd_n, 1'b0);
    chk("R9", "busy", busy, 1'b0);
  endtask

  task automatic t_wake_pd;
    send(2'b10);
    chk("R3", "pd_n", pd_n, 1'b1);
    chk("R3", "busy", busy, 1'b1);
    wait_n(PDW + LAT - 1);
    chk("R3", "valid early", data_valid, 1'b0);
    chk("R3", "busy early", busy, 1'b1);
    wait_n(1);
    chk("R3", "valid", data_valid, 1'b1);
    chk("R3", "busy", busy, 1'b0);
    chk("R10", "lines high", pd_n & slp_n, 1'b1);
    send(2'b11);
    chk("R9", "valid kept", data_valid, 1'b1);
  endtask

  task automatic t_run_to_sleep;
    send(2'b01);
    chk("R11", "slp_n", slp_n, 1'b0);
    chk("R11", "valid", data_valid, 1'b0);
    chk("R11", "pd_n", pd_n, 1'b1);
  endtask

  task automatic t_wake_sleep;
    send(2'b10);
    chk("R4", "slp_n", slp_n, 1'b1);
    chk("R4", "busy", busy, 1'b1);
    wait_n(SLW + LAT - 1);
    chk("R4", "valid early", data_valid, 1'b0);
    wait_n(1);
    chk("R4", "valid", data_valid, 1'b1);
  endtask

  task automatic t_run_repeat;
    send(2'b01);
    send(2'b10);
    wait_n(9);
    send(2'b10);
    wait_n(SLW + LAT - 10 - 1);
    chk("R8", "valid early", data_valid, 1'b0);
    wait_n(1);
    chk("R8", "valid on time", data_valid, 1'b1);
  endtask

  task automatic t_aborts;
    send(2'b00);
    chk("R6", "pd_n", pd_n, 1'b0);
    chk("R6", "valid", data_valid, 1'b0);
    send(2'b10);
    wait_n(5);
    send(2'b01);
    chk("R7", "slp_n wake abort", slp_n, 1'b0);
    chk("R7", "busy wake abort", busy, 1'b0);
    chk("R7", "pd_n wake abort", pd_n, 1'b1);
    send(2'b10);
    wait_n(SLW + 3);
    chk("R7", "busy in flush", busy, 1'b1);
    send(2'b00);
    chk("R7", "pd_n flush abort", pd_n, 1'b0);
    chk("R7", "busy flush abort", busy, 1'b0);
    chk("R6", "slp_n", slp_n, 1'b1);
    send(2'b01);
    chk("R5", "slp_n after pd", slp_n, 1'b1);
    wait_n(LAT + 2);
    chk("R5", "still down", pd_n, 1'b0);
    chk("R10", "valid low", data_valid, 1'b0);
  endtask

  initial begin
    t_reset();
    t_init_hold();
    t_ignored_in_pd();
    t_wake_pd();
    t_run_to_sleep();
    t_wake_sleep();
    t_run_repeat();
    t_aborts();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule